// File: doc/BRIEF.md
# Sleep Mode Clock-Gating Controller

This block manages low-power states for a small microcontroller core. Software writes a sleep-permit bit and a three-bit mode selector into a control register. When the core executes its sleep instruction, a one-cycle strobe reaches this block. If sleep is permitted at that moment, the block latches the chosen mode and turns off the clock-domain enables that belong to that mode. The domains are CPU, flash, I/O and the main oscillator.

While the core sleeps, a fixed-position vector of wake requests is compared against the set of sources that the current mode accepts. The first accepted request starts the wake sequence. After power-down only, the block first waits a programmable oscillator start-up count. In every mode it then holds the CPU for a fixed four-cycle halt. Finally it restores the CPU clock and pulses one of two outputs. One pulse means resume through the interrupt routine. The other means restart from the reset vector, and it is used when the accepted source was a reset.

Top module: `sleep_ctrl`

## Requirements
- R1: A sleep strobe while `sleep_enable` is 0 has no effect. A strobe while the core is not running (asleep, in start-up or in halt) also has no effect.
- R2: Mode 000 (light sleep) turns off the CPU and flash enables and keeps the I/O and oscillator enables on.
- R3: Mode 001 (quiet-conversion sleep) turns off the CPU, flash and I/O enables and keeps the oscillator enable on.
- R4: Mode 010 (deep sleep) turns off all four enables, including `osc_en`.
- R5: Mode codes 011 to 111 behave exactly like mode 000, in both clock gating and accepted wake sources.
- R6: `wake_req` bits are: 0 conversion done, 1 external reset, 2 watchdog reset, 3 watchdog interrupt, 4 brown-out reset, 5 two-wire interrupt, 6 two-wire address match, 7 timer-2 interrupt, 8 program-memory/EEPROM ready, 9 level interrupt on external lines 7:4, 10 external lines 3:0, 11 pin change, 12 symbol counter, 13 any other interrupt. Light sleep accepts all bits. Quiet-conversion sleep accepts bits 0,1,2,3,4,5,7,8,9,11. Deep sleep accepts bits 1,2,4,6,9,10,11,12. Requests that are not accepted leave the block asleep.
- R7: Start-up delay applies only when waking from deep sleep. If a wake is accepted at clock edge k, the resume pulse appears after edge k+4+`startup_cycles`. During start-up only `osc_en` is on.
- R8: Outside deep sleep, or with `startup_cycles`=0, the resume pulse appears after edge k+4. During the four halt cycles the CPU enable stays off and the other enables are on. The pulse lasts one cycle, and `cpu_clk_en` rises with it.
- R9: If the accepted request set contains bit 1, 2 or 4, the block pulses `resume_reset` and not `resume_isr`.
- R10: Entering light or quiet-conversion sleep with `adc_enabled`=1 gives a one-cycle `adc_start` pulse in the first sleep cycle. Deep sleep, or `adc_enabled`=0, gives no pulse.
- R11: After reset all four enables are on, and `sleeping`, `adc_start`, `resume_isr` and `resume_reset` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_enable | input | 1 | Sleep permitted |
| sleep_mode_sel | input | 3 | Requested sleep mode code |
| sleep_strobe | input | 1 | One-cycle sleep instruction strobe |
| adc_enabled | input | 1 | Converter is enabled |
| startup_cycles | input | STARTUP_W | Oscillator start-up delay in cycles |
| wake_req | input | 14 | Wake request vector |
| cpu_clk_en | output | 1 | CPU clock enable |
| flash_clk_en | output | 1 | Flash clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| osc_en | output | 1 | Main oscillator enable |
| adc_start | output | 1 | Conversion start pulse |
| sleeping | output | 1 | Core is not running |
| resume_isr | output | 1 | Resume via interrupt pulse |
| resume_reset | output | 1 | Resume via reset vector pulse |

## Verification
The hardest conditions to reach from the ports are a wake source arriving in a mode that must reject it, and a sleep strobe arriving in the middle of the halt window. To reach the first, the bench holds rejected request bits for several cycles in quiet-conversion and deep sleep before it raises an accepted bit. To reach the second, it raises the strobe while the halt window is running. A behavioural model tracks each cycle and counts the cycles from the accepted wake to the resume pulse, both with and without a start-up delay.

// File: rtl/sleepctl_pkg.sv
package sleepctl_pkg;

    localparam int NUM_WAKE    = 14;
    localparam int HALT_CYCLES = 4;

    localparam int W_CONV_DONE  = 0;
    localparam int W_EXT_RESET  = 1;
    localparam int W_WDOG_RESET = 2;
    localparam int W_WDOG_IRQ   = 3;
    localparam int W_BOD_RESET  = 4;
    localparam int W_TWI_IRQ    = 5;
    localparam int W_TWI_ADDR   = 6;
    localparam int W_TMR2_IRQ   = 7;
    localparam int W_NVM_READY  = 8;
    localparam int W_LVL_HI     = 9;
    localparam int W_EXT_LO     = 10;
    localparam int W_PIN_CHG    = 11;
    localparam int W_SYMCNT     = 12;
    localparam int W_OTHER_IRQ  = 13;

    typedef logic [NUM_WAKE-1:0] wake_vec_t;

    typedef enum logic [1:0] {GM_LIGHT, GM_QUIET, GM_DEEP} gate_mode_e;
    typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_STARTUP, ST_HALT} seq_state_e;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic osc;
    } clk_en_t;

    function automatic gate_mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'b001:  return GM_QUIET;
            3'b010:  return GM_DEEP;
            default: return GM_LIGHT;
        endcase
    endfunction

    function automatic wake_vec_t allowed_mask(input gate_mode_e m);
        wake_vec_t v;
        v = '0;
        case (m)
            GM_QUIET: begin
                v[W_CONV_DONE] = 1'b1; v[W_EXT_RESET] = 1'b1; v[W_WDOG_RESET] = 1'b1;
                v[W_WDOG_IRQ]  = 1'b1; v[W_BOD_RESET] = 1'b1; v[W_TWI_IRQ]    = 1'b1;
                v[W_TMR2_IRQ]  = 1'b1; v[W_NVM_READY] = 1'b1; v[W_LVL_HI]     = 1'b1;
                v[W_PIN_CHG]   = 1'b1;
            end
            GM_DEEP: begin
                v[W_EXT_RESET] = 1'b1; v[W_WDOG_RESET] = 1'b1; v[W_BOD_RESET] = 1'b1;
                v[W_TWI_ADDR]  = 1'b1; v[W_LVL_HI]     = 1'b1; v[W_EXT_LO]    = 1'b1;
                v[W_PIN_CHG]   = 1'b1; v[W_SYMCNT]     = 1'b1;
            end
            default: v = '1;
        endcase
        return v;
    endfunction

    function automatic wake_vec_t reset_class_mask();
        wake_vec_t v;
        v = '0;
        v[W_EXT_RESET]  = 1'b1;
        v[W_WDOG_RESET] = 1'b1;
        v[W_BOD_RESET]  = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/sleep_wake_filter.sv
module sleep_wake_filter
    import sleepctl_pkg::*;
(
    input  gate_mode_e mode,
    input  wake_vec_t  wake_req,
    output logic       wake_hit,
    output logic       wake_is_reset
);
    wake_vec_t allow;
    wake_vec_t rclass;
    wake_vec_t accepted;

    assign allow  = allowed_mask(mode);
    assign rclass = reset_class_mask();

    for (genvar i = 0; i < NUM_WAKE; i++) begin : g_src
        assign accepted[i] = wake_req[i] & allow[i];
    end

    assign wake_hit      = |accepted;
    assign wake_is_reset = |(accepted & rclass);
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
    import sleepctl_pkg::*;
#(
    parameter int STARTUP_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sleep_enable,
    input  logic [2:0]           sleep_mode_sel,
    input  logic                 sleep_strobe,
    input  logic                 adc_enabled,
    input  logic [STARTUP_W-1:0] startup_cycles,
    input  logic                 wake_hit,
    input  logic                 wake_is_reset,
    output seq_state_e           state,
    output gate_mode_e           mode,
    output logic                 adc_start,
    output logic                 resume_isr,
    output logic                 resume_reset
);
    localparam int CW = (STARTUP_W > 3) ? STARTUP_W : 3;

    logic [CW-1:0] cnt;
    logic          via_reset;
    gate_mode_e    next_mode;

    assign next_mode = decode_mode(sleep_mode_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_RUN;
            mode         <= GM_LIGHT;
            cnt          <= '0;
            via_reset    <= 1'b0;
            adc_start    <= 1'b0;
            resume_isr   <= 1'b0;
            resume_reset <= 1'b0;
        end else begin
            adc_start    <= 1'b0;
            resume_isr   <= 1'b0;
            resume_reset <= 1'b0;
            case (state)
                ST_RUN: begin
                    if (sleep_strobe && sleep_enable) begin
                        state     <= ST_SLEEP;
                        mode      <= next_mode;
                        adc_start <= adc_enabled && (next_mode != GM_DEEP);
                    end
                end
                ST_SLEEP: begin
                    if (wake_hit) begin
                        via_reset <= wake_is_reset;
                        if (mode == GM_DEEP && startup_cycles != '0) begin
                            state <= ST_STARTUP;
                            cnt   <= CW'(startup_cycles);
                        end else begin
                            state <= ST_HALT;
                            cnt   <= CW'(HALT_CYCLES);
                        end
                    end
                end
                ST_STARTUP: begin
                    if (cnt == CW'(1)) begin
                        state <= ST_HALT;
                        cnt   <= CW'(HALT_CYCLES);
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: begin
                    if (cnt == CW'(1)) begin
                        state        <= ST_RUN;
                        resume_isr   <= !via_reset;
                        resume_reset <= via_reset;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
            endcase
        end
    end

    // R1: a strobe without permission keeps the core running
    p_no_entry_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && sleep_strobe && !sleep_enable) |=> (state == ST_RUN));

    // R7: start-up phase only follows deep sleep
    p_startup_deep_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STARTUP) |-> (mode == GM_DEEP));

    // R8: a resume pulse is always preceded by the halt phase
    p_halt_before_resume_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(resume_isr) |-> $past(state == ST_HALT));

    // R9: never both resume kinds at once
    p_one_resume_r9: assert property (@(posedge clk) disable iff (rst)
        !(resume_isr && resume_reset));

    // R10: conversion start is a single-cycle pulse
    p_adc_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);
endmodule

// File: rtl/sleep_clk_gate.sv
module sleep_clk_gate
    import sleepctl_pkg::*;
(
    input  seq_state_e state,
    input  gate_mode_e mode,
    output clk_en_t    en
);
    always_comb begin
        en = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, osc: 1'b1};
        case (state)
            ST_SLEEP: begin
                en.cpu   = 1'b0;
                en.flash = 1'b0;
                en.io    = (mode == GM_LIGHT);
                en.osc   = (mode != GM_DEEP);
            end
            ST_STARTUP: begin
                en.cpu   = 1'b0;
                en.flash = 1'b0;
                en.io    = 1'b0;
            end
            ST_HALT: en.cpu = 1'b0;
            default: ;
        endcase
    end
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
    import sleepctl_pkg::*;
#(
    parameter int STARTUP_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sleep_enable,
    input  logic [2:0]           sleep_mode_sel,
    input  logic                 sleep_strobe,
    input  logic                 adc_enabled,
    input  logic [STARTUP_W-1:0] startup_cycles,
    input  logic [13:0]          wake_req,
    output logic                 cpu_clk_en,
    output logic                 flash_clk_en,
    output logic                 io_clk_en,
    output logic                 osc_en,
    output logic                 adc_start,
    output logic                 sleeping,
    output logic                 resume_isr,
    output logic                 resume_reset
);
    seq_state_e state;
    gate_mode_e mode;
    logic       wake_hit;
    logic       wake_is_reset;
    clk_en_t    en;

    sleep_wake_filter u_filter (
        .mode          (mode),
        .wake_req      (wake_req),
        .wake_hit      (wake_hit),
        .wake_is_reset (wake_is_reset)
    );

    sleep_seq #(.STARTUP_W(STARTUP_W)) u_seq (
        .clk            (clk),
        .rst            (rst),
        .sleep_enable   (sleep_enable),
        .sleep_mode_sel (sleep_mode_sel),
        .sleep_strobe   (sleep_strobe),
        .adc_enabled    (adc_enabled),
        .startup_cycles (startup_cycles),
        .wake_hit       (wake_hit),
        .wake_is_reset  (wake_is_reset),
        .state          (state),
        .mode           (mode),
        .adc_start      (adc_start),
        .resume_isr     (resume_isr),
        .resume_reset   (resume_reset)
    );

    sleep_clk_gate u_gate (
        .state (state),
        .mode  (mode),
        .en    (en)
    );

    assign cpu_clk_en   = en.cpu;
    assign flash_clk_en = en.flash;
    assign io_clk_en    = en.io;
    assign osc_en       = en.osc;
    assign sleeping     = (state != ST_RUN);

    // R4: deep sleep keeps the oscillator off until a wake is accepted
    p_deep_osc_off_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && mode == GM_DEEP) |-> !osc_en);

    // R6: with no accepted request the core stays asleep
    p_stay_asleep_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && !wake_hit) |=> sleeping);

    // R8: the CPU clock comes back together with a resume pulse
    p_cpu_back_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> (resume_isr || resume_reset));
endmodule

// File: tb/test_sleep_ctrl.sv
module test_sleep_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep_enable = 1'b0;
    logic [2:0]  sleep_mode_sel = 3'b000;
    logic        sleep_strobe = 1'b0;
    logic        adc_enabled = 1'b0;
    logic [7:0]  startup_cycles = 8'd0;
    logic [13:0] wake_req = '0;
    logic cpu_clk_en, flash_clk_en, io_clk_en, osc_en;
    logic adc_start, sleeping, resume_isr, resume_reset;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sleep_ctrl #(.STARTUP_W(8)) i_sleep_ctrl (
        .clk(clk), .rst(rst), .sleep_enable(sleep_enable), .sleep_mode_sel(sleep_mode_sel),
        .sleep_strobe(sleep_strobe), .adc_enabled(adc_enabled), .startup_cycles(startup_cycles),
        .wake_req(wake_req), .cpu_clk_en(cpu_clk_en), .flash_clk_en(flash_clk_en),
        .io_clk_en(io_clk_en), .osc_en(osc_en), .adc_start(adc_start), .sleeping(sleeping),
        .resume_isr(resume_isr), .resume_reset(resume_reset)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
        end
    endtask

    // Behavioural reference: phase 0 awake, 1 asleep, 2 oscillator warm-up, 3 halt
    int phase = 0, kind = 0, left = 0;
    bit reset_path = 0, m_isr = 0, m_rst = 0, m_adc = 0;
    function automatic int accepts(input int k);
        case (k)
            1: return 14'h0BBF;
            2: return 14'h1E56;
            default: return 14'h3FFF;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        m_isr = 0; m_rst = 0; m_adc = 0;
        if (rst) begin
            phase = 0; kind = 0; left = 0; reset_path = 0;
        end else if (phase == 0) begin
            if (sleep_strobe && sleep_enable) begin
                kind = (sleep_mode_sel == 3'd1) ? 1 : (sleep_mode_sel == 3'd2) ? 2 : 0;
                phase = 1;
                m_adc = adc_enabled && kind != 2;
            end
        end else if (phase == 1) begin
            int hit;
            hit = int'(wake_req) & accepts(kind);
            if (hit != 0) begin
                reset_path = (hit & 14'h0016) != 0;
                if (kind == 2 && startup_cycles != 0) begin phase = 2; left = startup_cycles; end
                else begin phase = 3; left = 4; end
            end
        end else if (phase == 2) begin
            if (left == 1) begin phase = 3; left = 4; end else left--;
        end else begin
            if (left == 1) begin phase = 0; m_isr = !reset_path; m_rst = reset_path; end
            else left--;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            string gt;
            gt = (phase == 2) ? "R7" : (phase == 3) ? "R8" : (kind == 1) ? "R3" : (kind == 2) ? "R4" : "R2";
            check(gt, "cpu_clk_en", cpu_clk_en, phase == 0);
            check(gt, "flash_clk_en", flash_clk_en, phase == 0 || phase == 3);
            check(gt, "io_clk_en", io_clk_en, phase == 0 || phase == 3 || (phase == 1 && kind == 0));
            check(gt, "osc_en", osc_en, !(phase == 1 && kind == 2));
            check("R6", "sleeping", sleeping, phase != 0);
            check("R8", "resume_isr", resume_isr, m_isr);
            check("R9", "resume_reset", resume_reset, m_rst);
            check("R10", "adc_start", adc_start, m_adc);
        end
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic go_sleep(input logic [2:0] code);
        sleep_mode_sel = code; sleep_enable = 1'b1; sleep_strobe = 1'b1;
        @(negedge clk);
        sleep_strobe = 1'b0;
    endtask

    task automatic wake_and_time(input int bitn, input string tag, input int exp_n, input bit exp_reset);
        int n;
        wake_req = 14'(1) << bitn;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) wake_req = '0;
        end while (!(resume_isr || resume_reset) && n < 60);
        check(tag, "cycles to resume", n, exp_n);
        check(tag, "reset path", resume_reset, exp_reset);
        check(tag, "isr path", resume_isr, !exp_reset);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11", "cpu after reset", cpu_clk_en, 1);
        check("R11", "osc after reset", osc_en, 1);
        check("R11", "sleeping after reset", sleeping, 0);
        check("R11", "pulses after reset", adc_start | resume_isr | resume_reset, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1: no permission
        sleep_enable = 1'b0; sleep_strobe = 1'b1;
        @(negedge clk);
        sleep_strobe = 1'b0;
        check("R1", "strobe without enable", sleeping, 0);

        // R2 + R10: light sleep with converter
        adc_enabled = 1'b1;
        go_sleep(3'b000);
        check("R10", "adc_start on light entry", adc_start, 1);
        check("R2", "io kept in light", io_clk_en, 1);
        @(negedge clk);
        check("R10", "adc_start one cycle", adc_start, 0);
        wake_and_time(13, "R8", 5, 0);

        // R3 + R6: quiet-conversion rejects other sources
        go_sleep(3'b001);
        check("R3", "io off in quiet", io_clk_en, 0);
        wake_req = 14'h3440;
        repeat (3) @(negedge clk);
        wake_req = '0;
        check("R6", "rejected in quiet", sleeping, 1);
        wake_and_time(0, "R6", 5, 0);

        // R4 + R7: deep sleep with warm-up
        startup_cycles = 8'd6;
        go_sleep(3'b010);
        check("R10", "no adc_start in deep", adc_start, 0);
        check("R4", "osc off in deep", osc_en, 0);
        wake_req = 14'h2009;
        repeat (3) @(negedge clk);
        wake_req = '0;
        check("R6", "rejected in deep", sleeping, 1);
        wake_and_time(10, "R7", 11, 0);

        // R7: deep sleep, zero warm-up; quiet never waits
        startup_cycles = 8'd0;
        go_sleep(3'b010);
        wake_and_time(12, "R7", 5, 0);
        startup_cycles = 8'd9;
        go_sleep(3'b001);
        wake_and_time(7, "R7", 5, 0);

        // R9: reset source
        go_sleep(3'b000);
        wake_and_time(1, "R9", 5, 1);
        go_sleep(3'b010);
        wake_and_time(4, "R9", 14, 1);

        // R5: reserved codes behave as light sleep
        go_sleep(3'b110);
        check("R5", "io on reserved", io_clk_en, 1);
        check("R5", "osc on reserved", osc_en, 1);
        wake_and_time(13, "R5", 5, 0);
        go_sleep(3'b011);
        wake_and_time(3, "R5", 5, 0);

        // R1: strobe during halt ignored; R10 no pulse when converter off
        adc_enabled = 1'b0;
        go_sleep(3'b000);
        check("R10", "no adc_start when disabled", adc_start, 0);
        wake_req = 14'h2000;
        @(negedge clk);
        wake_req = '0;
        sleep_strobe = 1'b1;
        @(negedge clk);
        sleep_strobe = 1'b0;
        repeat (5) @(negedge clk);
        check("R1", "strobe in halt ignored", sleeping, 0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule